// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes the accumulator, a second operand byte and a 5-bit operation code. It returns a result byte at once, combinationally. On the next rising clock edge it updates a flag register holding sign, zero, parity, carry and auxiliary (half) carry. The flags held in that register are also the carry and half-carry inputs that the operations consume.

The surrounding sequencer chooses when an operation counts by raising `exec_i`. To save or restore the flags it reads the packed status byte `psw_o` and writes one back through `psw_wr_i`/`psw_i`. Fetching operands, writing results to registers and sequencing stay outside the block.

Top module: `acc_alu`

## Requirements
- R1: After reset all five flags are 0, so `psw_o` reads 8'h02.
- R2: Codes 0 to 3 are add, add-with-carry, subtract and subtract-with-borrow, computing A+B, A+B+CY, A-B and A-B-CY modulo 256. CY is set on a carry out of bit 7 for the adds and on a borrow for the subtracts.
- R3: For the adds (codes 0, 1) AC is the carry from bit 3 into bit 4. For the subtracts and compare (codes 2, 3, 7) AC is 1 exactly when the low-nibble subtraction needs no borrow.
- R4: Codes 4, 5 and 6 give A AND B, A XOR B and A OR B, and clear both CY and AC.
- R5: Code 7 (compare) sets every flag as subtract does, while `result_o` stays equal to A.
- R6: Every operation that updates S, Z and P (codes 0 to 9 and 14) sets S to result bit 7, Z when the result is 0, and P when the result holds an even number of 1 bits.
- R7: Code 8 gives A+1 and code 9 gives A-1. Both leave CY unchanged. AC is 1 when A[3:0] is 4'hF for code 8, and when A[3:0] is non-zero for code 9.
- R8: Codes 10 to 13 rotate A and change only CY. Code 10 rotates left and copies bit 7 into bit 0 and CY. Code 11 rotates right and copies bit 0 into bit 7 and CY. Code 12 rotates left with the old CY entering bit 0 and bit 7 going to CY. Code 13 rotates right with the old CY entering bit 7 and bit 0 going to CY.
- R9: Code 14 (decimal adjust) runs two steps. Step 1 adds 6 when A[3:0] > 9 or AC is 1, and sets AC to the carry out of bit 3 of that addition (0 if step 1 is skipped). Step 2 adds 8'h60 to the step-1 byte when its upper nibble is > 9, when CY is 1, or when step 1 carried out of bit 7. Step 2 also sets CY when it adds; if it does not add, CY keeps its value.
- R10: Code 15 gives NOT A and changes no flag. Code 16 sets CY to 1. Code 17 inverts CY. Codes 16 and 17 output A and leave the other flags alone.
- R11: `psw_o` is {S, Z, 0, AC, 0, P, 1, CY} from bit 7 down to bit 0. When `psw_wr_i` is 1, the next edge loads S, Z, AC, P and CY from bits 7, 6, 4, 2 and 0 of `psw_i`, overriding any operation.
- R12: With `exec_i` low, or for codes 18 to 31, the flags do not change. Codes 18 to 31 also output A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Commit this cycle's flag update |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| psw_wr_i | input | 1 | Load flags from `psw_i` |
| psw_i | input | 8 | Status byte to restore |
| result_o | output | 8 | Result byte (combinational) |
| psw_o | output | 8 | Packed flag byte |

## Verification
The bound checker watches several rules on every cycle: the fixed bits of the status byte, flags holding when nothing executes, logic operations clearing both carries, increment and decrement keeping CY, compare leaving the accumulator on the output, zero tracking the committed result, set-carry, and restore priority. The arithmetic values themselves can only be shown by the bench's reference model across its scenarios. These include carry and borrow chains, half-carry on subtract, the four rotate variants, and the decimal-adjust corners where step one overflows or the stored carry forces the upper correction.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec_i,
  input  logic [4:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       psw_wr_i,
  input  logic [7:0] psw_i,
  output logic [7:0] result_o,
  output logic [7:0] psw_o
);
  localparam logic [4:0] OP_CMP = 5'd7,  OP_INC = 5'd8,  OP_DEC = 5'd9,
                         OP_RLC = 5'd10, OP_RRC = 5'd11, OP_RAL = 5'd12,
                         OP_RAR = 5'd13, OP_DAA = 5'd14, OP_CMA = 5'd15,
                         OP_STC = 5'd16, OP_CMC = 5'd17;

  logic fs, fz, fac, fp, fcy;
  logic [7:0] val;
  logic ncy, nac, szp;

  wire       two_op = (op_i[4:3] == 2'b00);
  wire       is_sub = (op_i[2:1] == 2'b01) | (op_i[2:0] == 3'b111);
  wire [7:0] b_eff  = is_sub ? ~opnd_i : opnd_i;
  wire       cin    = (op_i[2:0] == 3'b001) ? fcy :
                      (op_i[2:0] == 3'b011) ? ~fcy : is_sub;
  wire [8:0] sum    = {1'b0, acc_i} + {1'b0, b_eff} + {8'd0, cin};
  wire [4:0] lo_sum = {1'b0, acc_i[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, cin};

  wire       adj_lo = fac | (acc_i[3:0] > 4'd9);
  wire [8:0] step1  = {1'b0, acc_i} + (adj_lo ? 9'd6 : 9'd0);
  wire       adj_hi = fcy | step1[8] | (step1[7:4] > 4'd9);

  always_comb begin
    val = acc_i;
    ncy = fcy;
    nac = fac;
    szp = 1'b0;
    if (two_op) begin
      szp = 1'b1;
      case (op_i[2:0])
        3'b100: begin val = acc_i & opnd_i; ncy = 1'b0; nac = 1'b0; end
        3'b101: begin val = acc_i ^ opnd_i; ncy = 1'b0; nac = 1'b0; end
        3'b110: begin val = acc_i | opnd_i; ncy = 1'b0; nac = 1'b0; end
        default: begin
          val = sum[7:0];
          ncy = sum[8] ^ is_sub;
          nac = lo_sum[4];
        end
      endcase
    end else begin
      case (op_i)
        OP_INC: begin val = acc_i + 8'd1; nac = (acc_i[3:0] == 4'hF); szp = 1'b1; end
        OP_DEC: begin val = acc_i - 8'd1; nac = (acc_i[3:0] != 4'h0); szp = 1'b1; end
        OP_RLC: begin val = {acc_i[6:0], acc_i[7]}; ncy = acc_i[7]; end
        OP_RRC: begin val = {acc_i[0], acc_i[7:1]}; ncy = acc_i[0]; end
        OP_RAL: begin val = {acc_i[6:0], fcy}; ncy = acc_i[7]; end
        OP_RAR: begin val = {fcy, acc_i[7:1]}; ncy = acc_i[0]; end
        OP_DAA: begin
          val = step1[7:0] + (adj_hi ? 8'h60 : 8'h00);
          nac = adj_lo & (acc_i[3:0] > 4'd9);
          ncy = adj_hi;
          szp = 1'b1;
        end
        OP_CMA: val = ~acc_i;
        OP_STC: ncy = 1'b1;
        OP_CMC: ncy = ~fcy;
        default: ;
      endcase
    end
  end

  wire upd = exec_i & (op_i <= OP_CMC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fs, fz, fac, fp, fcy} <= 5'b0;
    end else if (psw_wr_i) begin
      {fs, fz, fac, fp, fcy} <= {psw_i[7], psw_i[6], psw_i[4], psw_i[2], psw_i[0]};
    end else if (upd) begin
      fcy <= ncy;
      fac <= nac;
      if (szp) begin
        fs <= val[7];
        fz <= (val == 8'd0);
        fp <= ~^val;
      end
    end
  end

  assign result_o = (op_i == OP_CMP) ? acc_i : val;
  assign psw_o    = {fs, fz, 1'b0, fac, 1'b0, fp, 1'b1, fcy};
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec_i,
  input logic [4:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic       psw_wr_i,
  input logic [7:0] psw_i,
  input logic [7:0] result_o,
  input logic [7:0] psw_o
);
  wire idle  = !psw_wr_i && (!exec_i || op_i > 5'd17);
  wire commit = exec_i && !psw_wr_i;

  assert_fixed_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    psw_o[5] == 1'b0 && psw_o[3] == 1'b0 && psw_o[1] == 1'b1);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(psw_o));

  assert_logic_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op_i >= 5'd4 && op_i <= 5'd6 |=> psw_o[0] == 1'b0 && psw_o[4] == 1'b0);

  assert_incdec_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (op_i == 5'd8 || op_i == 5'd9) |=> psw_o[0] == $past(psw_o[0]));

  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 5'd7 |-> result_o == acc_i);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op_i <= 5'd6 |=> psw_o[6] == ($past(result_o) == 8'd0));

  assert_set_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op_i == 5'd16 |=> psw_o[0]);

  assert_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    psw_wr_i |=> psw_o == (($past(psw_i) & 8'hD5) | 8'h02));
endmodule

bind acc_alu acc_alu_chk chk (.*);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, psw_i = '0;
  logic       psw_wr_i = 1'b0;
  logic [7:0] result_o, psw_o;

  int vectors = 0, miscompares = 0;
  int ms = 0, mz = 0, mac = 0, mp = 0, mcy = 0;
  int x_res, x_s, x_z, x_ac, x_p, x_cy;
  bit done = 0;

  always #5ns clk = ~clk;

  acc_alu uut (.*);

  function automatic string tag(int op, bit pw, bit ex);
    if (pw) return "R11";
    if (!ex || op > 17) return "R12";
    if (op < 4) return "R2";
    if (op < 7) return "R4";
    if (op == 7) return "R5";
    if (op < 10) return "R7";
    if (op < 14) return "R8";
    if (op == 14) return "R9";
    return "R10";
  endfunction

  function automatic int even_ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0);
  endfunction

  function automatic int pack();
    return (ms << 7) | (mz << 6) | (mac << 4) | (mp << 2) | 2 | mcy;
  endfunction

  task automatic calc(int op, int a, int b);
    int v = a, t, c;
    bit szp = 0;
    x_cy = mcy; x_ac = mac; x_s = ms; x_z = mz; x_p = mp;
    case (op)
      0, 1: begin
        c = (op == 1) ? mcy : 0;
        t = a + b + c;
        x_cy = (t > 255); x_ac = ((a & 15) + (b & 15) + c) > 15;  // R3
        v = t & 255; szp = 1;
      end
      2, 3, 7: begin
        c = (op == 3) ? mcy : 0;
        t = a - b - c;
        x_cy = (t < 0); x_ac = ((a & 15) - (b & 15) - c) >= 0;    // R3
        v = t & 255; szp = 1;
      end
      4: begin v = a & b; x_cy = 0; x_ac = 0; szp = 1; end
      5: begin v = a ^ b; x_cy = 0; x_ac = 0; szp = 1; end
      6: begin v = a | b; x_cy = 0; x_ac = 0; szp = 1; end
      8: begin v = (a + 1) & 255; x_ac = ((a & 15) == 15); szp = 1; end
      9: begin v = (a + 255) & 255; x_ac = ((a & 15) != 0); szp = 1; end
      10: begin x_cy = a >> 7; v = ((a << 1) | (a >> 7)) & 255; end
      11: begin x_cy = a & 1; v = (a >> 1) | ((a & 1) << 7); end
      12: begin x_cy = a >> 7; v = ((a << 1) | mcy) & 255; end
      13: begin x_cy = a & 1; v = (a >> 1) | (mcy << 7); end
      14: begin
        t = a; x_ac = 0;
        if ((a & 15) > 9 || mac) begin x_ac = ((a & 15) + 6) > 15; t = a + 6; end
        if (((t >> 4) & 15) > 9 || mcy || t > 255) begin t = (t & 255) + 96; x_cy = 1; end
        v = t & 255; szp = 1;
      end
      15: v = (~a) & 255;
      16: x_cy = 1;
      17: x_cy = 1 - mcy;
      default: ;
    endcase
    x_res = (op == 7) ? a : v;
    if (szp) begin x_s = v >> 7; x_z = (v == 0); x_p = even_ones(v); end  // R6
  endtask

  task automatic step(int op, int a, int b, bit ex = 1, bit pw = 0, int pin = 0);
    @(negedge clk);
    op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0];
    exec_i = ex; psw_wr_i = pw; psw_i = pin[7:0];
    #1;
    calc(op, a, b);
    vectors++;
    if (int'(result_o) != x_res) begin
      miscompares++;
      $display("FAIL %s result op=%0d a=%02h b=%02h: got %02h want %02h",
               tag(op, 0, 1), op, a, b, result_o, x_res);
    end
    @(posedge clk); #1;
    if (pw) begin
      ms = pin[7]; mz = pin[6]; mac = pin[4]; mp = pin[2]; mcy = pin[0];
    end else if (ex && op <= 17) begin
      ms = x_s; mz = x_z; mac = x_ac; mp = x_p; mcy = x_cy;
    end
    vectors++;
    if (int'(psw_o) != pack()) begin
      miscompares++;
      $display("FAIL %s flags op=%0d a=%02h b=%02h: got %02h want %02h",
               tag(op, pw, ex), op, a, b, psw_o, pack());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    miscompares++;
    $display("FAIL watchdog expired: got hang want completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;  // R1 reset state
    if (psw_o != 8'h02) begin
      miscompares++;
      $display("FAIL R1 reset psw: got %02h want 02", psw_o);
    end
    @(negedge clk); rst_n = 1'b1;
    // R2 carry and borrow chains
    step(0, 8'hFF, 8'h01); step(1, 8'h10, 8'h20); step(2, 8'h00, 8'h01);
    step(3, 8'h05, 8'h05); step(1, 8'h7F, 8'h00);
    // R3 half carry on add and subtract
    step(0, 8'h0F, 8'h01); step(2, 8'h10, 8'h01); step(2, 8'h1F, 8'h0E);
    // R4 logic clears carries after a set carry
    step(16, 0, 0); step(4, 8'hF0, 8'h3C); step(16, 0, 0); step(5, 8'hAA, 8'hAA);
    step(6, 8'h81, 8'h02);
    // R5 compare
    step(7, 8'h40, 8'h41); step(7, 8'h33, 8'h33);
    // R6 parity and sign
    step(6, 8'h80, 8'h00); step(6, 8'h03, 8'h00);
    // R7 increment and decrement around carry
    step(16, 0, 0); step(8, 8'hFF, 0); step(9, 8'h00, 0); step(9, 8'h10, 0);
    // R8 rotates with both carry states
    step(10, 8'h81, 0); step(11, 8'h01, 0); step(17, 0, 0); step(12, 8'h40, 0);
    step(16, 0, 0); step(13, 8'h02, 0); step(12, 8'h80, 0);
    // R9 decimal adjust corners
    step(0, 8'h19, 8'h28); step(14, 8'h41, 0);
    step(0, 8'h99, 8'h01); step(14, 8'h9A, 0);
    step(4, 0, 0); step(14, 8'hFA, 0);
    step(0, 8'h90, 8'h90); step(14, 8'h20, 0);
    step(4, 0, 0); step(14, 8'h15, 0);
    // R10 complement and carry control
    step(15, 8'h5A, 0); step(17, 0, 0); step(17, 0, 0);
    // R11 restore and priority over execution
    step(0, 8'hFF, 8'hFF, 1, 1, 8'h00); step(4, 0, 0, 1, 1, 8'hFF);
    // R12 no exec and unused codes
    step(0, 8'h00, 8'h00, 0); step(20, 8'h77, 8'h11); step(31, 8'h00, 8'h01);
    for (int i = 0; i < 800; i++) begin
      int op = $urandom_range(0, 31);
      if (op > 19 && $urandom_range(0, 3) != 0) op = $urandom_range(0, 17);
      step(op, $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 255));
    end
    finish_run();
  end
endmodule